// File: doc/BRIEF.md
# Runtime-Configurable Multi-Lane Byte Striper

The block spreads a byte stream over up to sixteen parallel lanes and merges lane bytes back into a single stream. On the transmit side, bytes arrive on a valid/ready input. They are gathered into a group with one byte for each active lane. Once the group is complete, every active lane is strobed in the same cycle. Byte k of a group lands on lane k, so the whole stream is laid out round-robin over the active lanes.

The active lane count comes from a two-bit width select, which is driven by whatever logic settles the link width. The count can drop while traffic is flowing, with no reset. A new select value is taken only when a group starts, so each group is striped at one width and always begins on lane 0.

The receive path is independent. It reads the size of each incoming group from the pattern of lane strobes. It then emits the bytes of lanes 0 to n-1 one per cycle through a small byte buffer. Consecutive groups therefore come out back to back, including across a width reduction, provided the lanes carry at most one byte per cycle on average, which is the rate the transmit path itself produces.

Top module: `lane_stripe`

## Requirements
- R1: After a group's last byte is accepted, all of that group's lanes are strobed together in the next cycle, with byte k of the group (counted from 0) on lane k; no lane is strobed in any other cycle.
- R2: Width select code 0 gives 1 lane (strobe mask 0x0001), code 1 gives 4 lanes (0x000F), code 2 gives 8 lanes (0x00FF) and code 3 gives 16 lanes (0xFFFF); no other nonzero mask ever appears on the transmit strobes.
- R3: The width select is sampled with the first byte of each group. A change while a group is partly collected does not alter that group, and the following group uses the new width starting on lane 0.
- R4: In every cycle, any lane whose strobe is low drives an all-zero byte.
- R5: While reset is asserted, no lane is strobed, out_valid_o is low and in_ready_o is low. in_ready_o is high from the first clock edge after reset is released.
- R6: When rx_lane_vld_i equals one of the four masks of R2, the bytes on lanes 0 to n-1 are output in lane order, one per cycle. The first is output in the cycle after the group is presented, if no earlier bytes are waiting.
- R7: A receive strobe pattern other than the four masks of R2 (including partial or gapped patterns) is ignored and produces no output byte.
- R8: With the transmit lanes looped back to the receive lanes, an arbitrary byte stream with idle gaps and mid-stream width reductions comes out complete and in its original order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | Negotiated lane-count code (see R2) |
| in_data_i | input | 8 | Transmit stream byte |
| in_valid_i | input | 1 | Transmit byte valid |
| in_ready_o | output | 1 | Transmit byte ready |
| tx_lane_data_o | output | 128 | Per-lane bytes, lane i at bits 8i+7:8i |
| tx_lane_vld_o | output | 16 | Per-lane strobe |
| rx_lane_data_i | input | 128 | Received per-lane bytes, lane i at bits 8i+7:8i |
| rx_lane_vld_i | input | 16 | Received per-lane strobe |
| out_data_o | output | 8 | Merged stream byte |
| out_valid_o | output | 1 | Merged byte valid |

## Verification
Single groups are sent at each width code in a mixed order, which separates a wrong code-to-mask mapping from a wrong byte-to-lane placement and confirms the one-cycle strobe and output latencies. A select change inside a partly collected group shows whether the width is sampled only at the group boundary. Partial and gapped strobe patterns driven directly onto the receive lanes separate real groups from noise. A long random stream with idle gaps and three width reductions, looped back, exposes any byte reordering or loss when a wide group is still draining while narrower groups arrive.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  localparam int NUM_LANES = 16;
  localparam int LCNT_W    = $clog2(NUM_LANES) + 1;

  function automatic logic [LCNT_W-1:0] lanes_of(input logic [1:0] code);
    case (code)
      2'd0:    return LCNT_W'(1);
      2'd1:    return LCNT_W'(4);
      2'd2:    return LCNT_W'(8);
      default: return LCNT_W'(16);
    endcase
  endfunction

  function automatic logic [NUM_LANES-1:0] mask_of(input logic [1:0] code);
    logic [NUM_LANES-1:0] m;
    for (int i = 0; i < NUM_LANES; i++) m[i] = (LCNT_W'(i) < lanes_of(code));
    return m;
  endfunction

  // lane count of a legal strobe pattern, 0 when the pattern is not a group
  function automatic logic [LCNT_W-1:0] group_size(input logic [NUM_LANES-1:0] v);
    logic [LCNT_W-1:0] n;
    n = '0;
    for (int c = 0; c < 4; c++)
      if (v == mask_of(2'(c))) n = lanes_of(2'(c));
    return n;
  endfunction
endpackage

// File: rtl/stripe_tx.sv
module stripe_tx
  import stripe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  width_sel_i,
  input  logic [DATA_W-1:0]           in_data_i,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  output logic [NUM_LANES*DATA_W-1:0] lane_data_o,
  output logic [NUM_LANES-1:0]        lane_vld_o
);
  localparam int CNT_W = $clog2(NUM_LANES);

  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        code_q;
  logic [DATA_W-1:0] hold_q [NUM_LANES];
  logic              rdy_q;

  logic [1:0]        code_eff;
  logic [LCNT_W-1:0] n_eff;
  logic              accept, last;

  // width is only taken at a group boundary
  always_comb begin
    code_eff = (cnt_q == '0) ? width_sel_i : code_q;
    n_eff    = lanes_of(code_eff);
    accept   = in_valid_i & rdy_q;
    last     = accept && ({1'b0, cnt_q} == n_eff - LCNT_W'(1));
  end

  assign in_ready_o = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
      rdy_q  <= 1'b0;
      for (int i = 0; i < NUM_LANES; i++) hold_q[i] <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (accept) begin
        hold_q[cnt_q] <= in_data_i;
        if (cnt_q == '0) code_q <= code_eff;
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_vld_o[i]                  <= 1'b0;
        lane_data_o[i*DATA_W +: DATA_W] <= '0;
      end else if (last && (LCNT_W'(i) < n_eff)) begin
        lane_vld_o[i]                  <= 1'b1;
        lane_data_o[i*DATA_W +: DATA_W] <= (CNT_W'(i) == cnt_q) ? in_data_i : hold_q[i];
      end else begin
        lane_vld_o[i]                  <= 1'b0;
        lane_data_o[i*DATA_W +: DATA_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/stripe_rx.sv
module stripe_rx
  import stripe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LANES*DATA_W-1:0] lane_data_i,
  input  logic [NUM_LANES-1:0]        lane_vld_i,
  output logic [DATA_W-1:0]           out_data_o,
  output logic                        out_valid_o
);
  localparam int DEPTH = 2 * NUM_LANES;
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [PTR_W:0]    cnt_q;
  logic [LCNT_W-1:0] n_grp;
  logic              pop;

  always_comb begin
    n_grp = group_size(lane_vld_i);
    pop   = (cnt_q != '0);
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_LANES; i++)
      if (LCNT_W'(i) < n_grp) mem[PTR_W'(wp_q + PTR_W'(i))] <= lane_data_i[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= PTR_W'(wp_q + PTR_W'(n_grp));
      rp_q  <= rp_q + PTR_W'(pop);
      cnt_q <= cnt_q + (PTR_W+1)'(n_grp) - (PTR_W+1)'(pop);
    end
  end

  assign out_valid_o = pop;
  assign out_data_o  = mem[rp_q];
endmodule

// File: rtl/lane_stripe.sv
module lane_stripe
  import stripe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  width_sel_i,
  input  logic [DATA_W-1:0]           in_data_i,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  output logic [NUM_LANES*DATA_W-1:0] tx_lane_data_o,
  output logic [NUM_LANES-1:0]        tx_lane_vld_o,
  input  logic [NUM_LANES*DATA_W-1:0] rx_lane_data_i,
  input  logic [NUM_LANES-1:0]        rx_lane_vld_i,
  output logic [DATA_W-1:0]           out_data_o,
  output logic                        out_valid_o
);
  stripe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .width_sel_i (width_sel_i),
    .in_data_i   (in_data_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .lane_data_o (tx_lane_data_o),
    .lane_vld_o  (tx_lane_vld_o)
  );

  stripe_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lane_data_i (rx_lane_data_i),
    .lane_vld_i  (rx_lane_vld_i),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o)
  );
endmodule

// File: rtl/lane_stripe_chk.sv
module lane_stripe_chk
  import stripe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  width_sel_i,
  input logic [DATA_W-1:0]           in_data_i,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic [NUM_LANES*DATA_W-1:0] tx_lane_data_o,
  input logic [NUM_LANES-1:0]        tx_lane_vld_o,
  input logic [NUM_LANES*DATA_W-1:0] rx_lane_data_i,
  input logic [NUM_LANES-1:0]        rx_lane_vld_i,
  input logic [DATA_W-1:0]           out_data_o,
  input logic                        out_valid_o
);
  logic [NUM_LANES*DATA_W-1:0] vld_wide;
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_w
    assign vld_wide[i*DATA_W +: DATA_W] = {DATA_W{tx_lane_vld_o[i]}};
  end

  logic tx_mask_ok, rx_grp;
  assign tx_mask_ok = (tx_lane_vld_o == '0) || (group_size(tx_lane_vld_o) != '0);
  assign rx_grp     = (group_size(rx_lane_vld_i) != '0);

  AST_TX_MASK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mask_ok);                                                                 // R2
  AST_IDLE_LANE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lane_data_o & ~vld_wide) == '0);                                         // R4
  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_lane_vld_o) |-> $past(in_valid_i && in_ready_o));                       // R1
  AST_READY_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> in_ready_o);                                                      // R5
  AST_RX_GROUP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_grp |=> out_valid_o);                                                     // R6
  AST_RX_NOISE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o && !rx_grp) |=> !out_valid_o);                                 // R7
endmodule

bind lane_stripe lane_stripe_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lane_stripe_bench.sv
module lane_stripe_bench;
  localparam int CLK_P = 10;
  localparam int NL    = 16;
  localparam int NT    = 8;
  localparam int TBL_CODE [NT] = '{3, 2, 1, 0, 1, 3, 0, 2};
  localparam int TBL_N    [NT] = '{16, 8, 4, 1, 4, 16, 1, 8};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    width_sel = 2'd0;
  logic [7:0]    in_data = 8'd0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [NL*8-1:0] tx_data, rx_data, drv_data = '0;
  logic [NL-1:0] tx_vld, rx_vld, drv_vld = '0;
  logic          lb = 1'b1;
  logic [7:0]    out_data;
  logic          out_valid;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] sb [0:4095];
  int wr = 0;
  int rd = 0;
  logic [7:0] grp [NL];

  always #(CLK_P/2) clk = ~clk;

  assign rx_data = lb ? tx_data : drv_data;
  assign rx_vld  = lb ? tx_vld  : drv_vld;

  lane_stripe u_lane_stripe (
    .clk_i(clk), .rst_ni(rst_n), .width_sel_i(width_sel),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .tx_lane_data_o(tx_data), .tx_lane_vld_o(tx_vld),
    .rx_lane_data_i(rx_data), .rx_lane_vld_i(rx_vld),
    .out_data_o(out_data), .out_valid_o(out_valid)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [NL-1:0] mask_n(input int n);
    return (n >= NL) ? '1 : NL'((32'd1 << n) - 1);
  endfunction

  // merged output scoreboard: R6/R8 ordering
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd == wr) chk(1'b0, "R7 unexpected output byte", {24'd0, out_data}, 32'd0);
      else begin
        chk(out_data == sb[rd], "R8 merged byte order", {24'd0, out_data}, {24'd0, sb[rd]});
        rd++;
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    sb[wr]   = b;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_strobe(input int n, input string tag);
    chk(tx_vld == mask_n(n), tag, {16'd0, tx_vld}, {16'd0, mask_n(n)});
    for (int j = 0; j < NL; j++)
      chk(tx_data[j*8 +: 8] == ((j < n) ? grp[j] : 8'd0), "R1/R4 lane byte",
          {24'd0, tx_data[j*8 +: 8]}, {24'd0, (j < n) ? grp[j] : 8'd0});
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL R8 watchdog expired");
    report();
    $finish;
  end

  initial begin
    // R5 reset state
    idle(3);
    chk(tx_vld == '0, "R5 no strobe in reset", {16'd0, tx_vld}, 32'd0);
    chk(!out_valid, "R5 out_valid low in reset", {31'd0, out_valid}, 32'd0);
    chk(!in_ready, "R5 in_ready low in reset", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R5 in_ready after release", {31'd0, in_ready}, 32'd1);

    // table: one group per width code (R1, R2, R6)
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      width_sel = 2'(TBL_CODE[t]);
      for (int j = 0; j < TBL_N[t]; j++) begin
        grp[j] = 8'($urandom);
        push_byte(grp[j]);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check_strobe(TBL_N[t], "R2 strobe mask for code");
      chk(!out_valid, "R6 no output before group", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      chk(tx_vld == '0, "R1 single strobe cycle", {16'd0, tx_vld}, 32'd0);
      chk(out_valid && out_data == grp[0], "R6 first byte latency", {23'd0, out_valid, out_data}, {23'd1, grp[0]});
      idle(20);
    end

    // R3 select change inside a group
    @(negedge clk);
    width_sel = 2'd3;
    for (int j = 0; j < NL; j++) begin
      grp[j] = 8'($urandom);
      push_byte(grp[j]);
      if (j == 4) width_sel = 2'd1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_strobe(16, "R3 group kept old width");
    idle(20);
    for (int j = 0; j < 4; j++) begin
      grp[j] = 8'($urandom);
      push_byte(grp[j]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_strobe(4, "R3 next group new width");
    idle(20);

    // R7 noise patterns on receive lanes
    lb = 1'b0;
    drv_data = {NL{8'hA5}};
    @(negedge clk) drv_vld = 16'h0003;
    @(negedge clk) drv_vld = 16'h00F0;
    @(negedge clk) drv_vld = 16'h7FFF;
    @(negedge clk) drv_vld = 16'h0000;
    chk(!out_valid, "R7 noise ignored", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk(!out_valid, "R7 noise ignored late", {31'd0, out_valid}, 32'd0);
    // R6 direct legal group
    drv_data = '0;
    drv_data[31:0] = 32'h44332211;
    drv_vld = 16'h000F;
    for (int j = 0; j < 4; j++) begin
      sb[wr] = 8'(8'h11 * (j + 1));
      wr++;
    end
    @(negedge clk) drv_vld = '0;
    idle(8);
    chk(rd == wr, "R6 direct group drained", rd, wr);
    lb = 1'b1;

    // R8 random stream with reductions
    width_sel = 2'd3;
    for (int k = 0; k < 480; k++) begin
      @(negedge clk);
      if (k == 150) width_sel = 2'd2;
      if (k == 260) width_sel = 2'd1;
      if (k == 360) width_sel = 2'd0;
      in_valid = (($urandom % 8) != 0) || (k >= 440);
      in_data  = 8'($urandom);
      if (in_valid) begin
        sb[wr] = in_data;
        wr++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    idle(60);
    chk(rd == wr, "R8 all bytes delivered", rd, wr);

    report();
    $finish;
  end
endmodule